// File: doc/BRIEF.md
# Sub-Dword Operand Select Merger

This datapath block takes two 32-bit source operands and, for each, picks the whole dword, one of its four bytes or one of its two 16-bit halves. Each picked field is widened back to 32 bits. The widening copies the field's top bit when that operand's sign flag is set, and fills with zeros otherwise. The two widened values are added.

The sum is then cut down to the width of a chosen destination field and written into that field of the previous destination value. The rest of the destination word is filled according to a fill policy:

- keep the old bits,
- clear them, or
- extend the field's top bit upward while clearing the bits below the field.

The merged word is registered. It appears one clock after a valid input, together with a valid strobe. An execution pipeline uses the block to run integer adds on packed sub-dword operands without separate unpack and repack steps.

Top module: `sdw_merge_unit`

## Requirements
- R1: Selector code 0 picks bits 31:0. Codes 1, 2, 3 and 4 pick bits 7:0, 15:8, 23:16 and 31:24. Code 5 picks bits 15:0 and code 6 picks bits 31:16. Code 7 behaves as code 0. This holds for both source selectors and for the destination selector.
- R2: A sub-dword source field whose sign flag is 0 is zero-extended to 32 bits.
- R3: A sub-dword source field whose sign flag is 1 is extended by copying its top bit. With selector code 0 or 7, the sign flag has no effect.
- R4: The 32-bit sum of the two extended sources is truncated to the destination field width and placed at the destination field position. Carries out of the field are lost.
- R5: Fill code 0 (the reset default) and fill code 3 keep every destination bit outside the field from the old destination input.
- R6: Fill code 1 clears every destination bit outside the field.
- R7: Fill code 2 sets every destination bit above the field to the field's top bit and clears every bit below the field.
- R8: The result and a high valid strobe appear on the clock edge after an edge that samples in_valid high. When in_valid is low, the strobe goes low on the next edge and the result holds its value.
- R9: After reset, the result is 0 and the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| dst_old | input | 32 | Previous destination value |
| sel_a | input | 3 | Field selector for src_a |
| sel_b | input | 3 | Field selector for src_b |
| sel_d | input | 3 | Destination field selector |
| fill_mode | input | 2 | Unselected destination bit policy |
| sx_a | input | 1 | Sign-extend flag for src_a |
| sx_b | input | 1 | Sign-extend flag for src_b |
| dst_out | output | 32 | Registered merged destination |
| out_valid | output | 1 | Result valid strobe |

## Verification
Two conditions are hard to reach from the ports. The first is when the sign-extension fill sees a field whose top bit is set only because a carry or a sign-extended operand crossed into it. The second is when a sign-extended narrow source meets a wider destination field. Random operands rarely land on those exact boundary values, so directed cases force them. Examples are 0xFF plus 1 into a byte field, and a negative byte widened into a halfword. An exhaustive sweep then covers every combination of the three selectors, the four fill codes and both sign flags, including the reserved selector code.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [2:0] {
    SEL_FULL  = 3'd0,
    SEL_B0    = 3'd1,
    SEL_B1    = 3'd2,
    SEL_B2    = 3'd3,
    SEL_B3    = 3'd4,
    SEL_H0    = 3'd5,
    SEL_H1    = 3'd6,
    SEL_ALIAS = 3'd7
  } sdw_sel_e;

  typedef enum logic [1:0] {
    FILL_KEEP  = 2'd0,
    FILL_ZERO  = 2'd1,
    FILL_SIGN  = 2'd2,
    FILL_KEEP3 = 2'd3
  } sdw_fill_e;

  localparam int unsigned NUM_SEL = 3;
endpackage

// File: rtl/sdw_field_decode.sv
module sdw_field_decode #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W = $clog2(DATA_W)
) (
  input  logic [2:0]        sel,
  output logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] fmask,
  output logic [SH_W-1:0]   topidx,
  output logic              is_full
);
  import sdw_pkg::*;
  localparam int unsigned BYTE_W = DATA_W / 4;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] BMASK = ONES >> (DATA_W - BYTE_W);
  localparam logic [DATA_W-1:0] HMASK = ONES >> (DATA_W - HALF_W);

  always_comb begin
    shamt   = '0;
    fmask   = ONES;
    topidx  = SH_W'(DATA_W - 1);
    is_full = 1'b1;
    case (sdw_sel_e'(sel))
      SEL_B0, SEL_B1, SEL_B2, SEL_B3: begin
        shamt   = SH_W'((sel - 3'd1) * BYTE_W);
        fmask   = BMASK;
        topidx  = SH_W'(BYTE_W - 1);
        is_full = 1'b0;
      end
      SEL_H0, SEL_H1: begin
        shamt   = SH_W'((sel - 3'd5) * HALF_W);
        fmask   = HMASK;
        topidx  = SH_W'(HALF_W - 1);
        is_full = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdw_src_extract.sv
module sdw_src_extract #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] fmask,
  input  logic [SH_W-1:0]   topidx,
  input  logic              is_full,
  input  logic              sx,
  output logic [DATA_W-1:0] val
);
  logic [DATA_W-1:0] raw;
  logic              top;

  always_comb begin
    raw = (src >> shamt) & fmask;
    top = raw[topidx];
    if (sx && !is_full && top) val = raw | ~fmask;
    else                       val = raw;
  end

  // R3: a full-width pick passes the operand unchanged whatever the flag
  always_comb begin
    if (is_full) assert_full_passthru_R3: assert (val == src);
  end
endmodule

// File: rtl/sdw_dst_merge.sv
module sdw_dst_merge #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] sum,
  input  logic [DATA_W-1:0] old,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] fmask,
  input  logic [SH_W-1:0]   topidx,
  input  logic [1:0]        fill,
  output logic [DATA_W-1:0] merged
);
  import sdw_pkg::*;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] fld, placed, pmask, lo_mask, hi_mask;
  logic              top;

  always_comb begin
    fld     = sum & fmask;
    top     = fld[topidx];
    placed  = fld << shamt;
    pmask   = fmask << shamt;
    lo_mask = (ONE << shamt) - ONE;
    hi_mask = ~(pmask | lo_mask);
    case (sdw_fill_e'(fill))
      FILL_ZERO: merged = placed;
      FILL_SIGN: merged = placed | (top ? hi_mask : '0);
      default:   merged = placed | (old & ~pmask);
    endcase
  end
endmodule

// File: rtl/sdw_merge_unit.sv
module sdw_merge_unit #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [2:0]        sel_a,
  input  logic [2:0]        sel_b,
  input  logic [2:0]        sel_d,
  input  logic [1:0]        fill_mode,
  input  logic              sx_a,
  input  logic              sx_b,
  output logic [DATA_W-1:0] dst_out,
  output logic              out_valid
);
  import sdw_pkg::*;
  localparam int unsigned SH_W = $clog2(DATA_W);
  localparam int unsigned BYTE_W = DATA_W / 4;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [2:0]        sel_v  [NUM_SEL];
  logic [SH_W-1:0]   sh_v   [NUM_SEL];
  logic [DATA_W-1:0] mk_v   [NUM_SEL];
  logic [SH_W-1:0]   tp_v   [NUM_SEL];
  logic              full_v [NUM_SEL];

  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;
  assign sel_v[2] = sel_d;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_dec
    sdw_field_decode #(.DATA_W(DATA_W)) u_dec (
      .sel(sel_v[g]), .shamt(sh_v[g]), .fmask(mk_v[g]),
      .topidx(tp_v[g]), .is_full(full_v[g])
    );
  end

  logic [DATA_W-1:0] ext_a, ext_b, sum, merged;

  sdw_src_extract #(.DATA_W(DATA_W)) u_ext_a (
    .src(src_a), .shamt(sh_v[0]), .fmask(mk_v[0]), .topidx(tp_v[0]),
    .is_full(full_v[0]), .sx(sx_a), .val(ext_a)
  );
  sdw_src_extract #(.DATA_W(DATA_W)) u_ext_b (
    .src(src_b), .shamt(sh_v[1]), .fmask(mk_v[1]), .topidx(tp_v[1]),
    .is_full(full_v[1]), .sx(sx_b), .val(ext_b)
  );

  assign sum = ext_a + ext_b;

  sdw_dst_merge #(.DATA_W(DATA_W)) u_merge (
    .sum(sum), .old(dst_old), .shamt(sh_v[2]), .fmask(mk_v[2]),
    .topidx(tp_v[2]), .fill(fill_mode), .merged(merged)
  );

  logic [DATA_W-1:0] dst_d, dst_q;
  logic              vld_d, vld_q;

  always_comb begin
    vld_d = in_valid;
    dst_d = dst_q;
    if (in_valid) dst_d = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dst_q <= dst_d;
      vld_q <= vld_d;
    end
  end

  assign dst_out   = dst_q;
  assign out_valid = vld_q;

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(dst_out)));
  assert_keep_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_mode == 2'd0 && sel_d == 3'd1)
      |=> dst_out[DATA_W-1:BYTE_W] == $past(dst_old[DATA_W-1:BYTE_W]));
  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_mode == 2'd1 && sel_d == 3'd4)
      |=> dst_out[DATA_W-BYTE_W-1:0] == '0);
  assert_sign_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill_mode == 2'd2 && sel_d == 3'd5)
      |=> dst_out[DATA_W-1:HALF_W] == {HALF_W{dst_out[HALF_W-1]}});
endmodule

// File: tb/sdw_merge_unit_test.sv
`timescale 1ns/1ps
module sdw_merge_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src_a, src_b, dst_old;
  logic [2:0]  sel_a, sel_b, sel_d;
  logic [1:0]  fill_mode;
  logic        sx_a, sx_b;
  logic [31:0] dst_out;
  logic        out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdw_merge_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .dst_old(dst_old), .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d),
    .fill_mode(fill_mode), .sx_a(sx_a), .sx_b(sx_b),
    .dst_out(dst_out), .out_valid(out_valid)
  );

  function automatic void fpos(input logic [2:0] s, output int lo, output int w);
    case (s)
      3'd1: begin lo = 0;  w = 8;  end
      3'd2: begin lo = 8;  w = 8;  end
      3'd3: begin lo = 16; w = 8;  end
      3'd4: begin lo = 24; w = 8;  end
      3'd5: begin lo = 0;  w = 16; end
      3'd6: begin lo = 16; w = 16; end
      default: begin lo = 0; w = 32; end
    endcase
  endfunction

  function automatic logic [31:0] ref_ext(input logic [31:0] v, input logic [2:0] s, input logic sx);
    int lo, w;
    logic [31:0] r;
    fpos(s, lo, w);
    r = '0;
    for (int i = 0; i < 32; i++)
      if (i < w) r[i] = v[lo+i];
      else       r[i] = sx ? v[lo+w-1] : 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] ref_merge(input logic [31:0] s, input logic [31:0] old,
                                            input logic [2:0] sd, input logic [1:0] fm);
    int lo, w;
    logic [31:0] r;
    fpos(sd, lo, w);
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (i >= lo && i < lo + w)  r[i] = s[i-lo];
      else if (fm == 2'd1)        r[i] = 1'b0;
      else if (fm == 2'd2)        r[i] = (i >= lo + w) ? s[w-1] : 1'b0;
      else                        r[i] = old[i];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] o, input logic [2:0] sa, input logic [2:0] sb,
                       input logic [2:0] sd, input logic [1:0] fm, input logic xa, input logic xb);
    in_valid = v; src_a = a; src_b = b; dst_old = o;
    sel_a = sa; sel_b = sb; sel_d = sd; fill_mode = fm; sx_a = xa; sx_b = xb;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] o, input logic [2:0] sa, input logic [2:0] sb,
                     input logic [2:0] sd, input logic [1:0] fm, input logic xa, input logic xb,
                     input logic [31:0] exp);
    drive(1'b1, a, b, o, sa, sb, sd, fm, xa, xb);
    check(tag, {31'd0, out_valid}, 32'd1);
    check(tag, dst_out, exp);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, o, exp;
    string tag;
    void'($urandom(32'h5D3A_91C7));
    rst_n = 1'b0;
    in_valid = 0; src_a = 0; src_b = 0; dst_old = 0;
    sel_a = 0; sel_b = 0; sel_d = 0; fill_mode = 0; sx_a = 0; sx_b = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", dst_out, 32'd0);
    check("R9", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: code 7 acts as the full dword; code 3 picks bits 23:16
    run("R1", 32'h1234_5678, 32'h0, 32'hFFFF_FFFF, 3'd7, 3'd0, 3'd7, 2'd0, 1'b1, 1'b0, 32'h1234_5678);
    run("R1", 32'h1234_5678, 32'h0, 32'hFFFF_FFFF, 3'd3, 3'd0, 3'd1, 2'd1, 1'b0, 1'b0, 32'h0000_0034);
    // R2: zero extension keeps the carry into bit 8
    run("R2", 32'h0000_00F0, 32'h0000_0010, 32'h0, 3'd1, 3'd1, 3'd5, 2'd1, 1'b0, 1'b0, 32'h0000_0100);
    // R3: sign extension of 0xF0 cancels the +0x10
    run("R3", 32'h0000_00F0, 32'h0000_0010, 32'h0, 3'd1, 3'd1, 3'd5, 2'd1, 1'b1, 1'b0, 32'h0000_0000);
    // R3: flag ignored for the full dword
    run("R3", 32'h0000_0080, 32'h0, 32'h0, 3'd0, 3'd0, 3'd0, 2'd1, 1'b1, 1'b1, 32'h0000_0080);
    // R3: negative byte from bits 31:24 widened into a halfword destination
    run("R3", 32'h8000_0000, 32'h0000_0001, 32'h0, 3'd4, 3'd5, 3'd5, 2'd1, 1'b1, 1'b0, 32'h0000_FF81);
    // R4: carry out of a byte field is lost; R5 keeps the other bytes
    run("R4", 32'h0000_00FF, 32'h0000_0001, 32'hAABB_CCDD, 3'd1, 3'd1, 3'd2, 2'd0, 1'b0, 1'b0, 32'hAABB_00DD);
    // R5: fill code 3 also keeps old bits
    run("R5", 32'h0000_1234, 32'h0, 32'hAABB_CCDD, 3'd5, 3'd0, 3'd6, 2'd3, 1'b0, 1'b0, 32'h1234_CCDD);
    // R6: clear around a high byte
    run("R6", 32'h0000_0042, 32'h0, 32'hFFFF_FFFF, 3'd1, 3'd0, 3'd4, 2'd1, 1'b0, 1'b0, 32'h4200_0000);
    // R7: sign fill above, zero below
    run("R7", 32'h0000_0080, 32'h0, 32'hFFFF_FFFF, 3'd1, 3'd0, 3'd2, 2'd2, 1'b0, 1'b0, 32'hFFFF_8000);
    run("R7", 32'h0000_8001, 32'h0, 32'hFFFF_FFFF, 3'd5, 3'd0, 3'd6, 2'd2, 1'b0, 1'b0, 32'h8001_0000);
    // R7: top bit set only by a carry into bit 7
    run("R7", 32'h0000_007F, 32'h0000_0001, 32'h0, 3'd1, 3'd1, 3'd1, 2'd2, 1'b0, 1'b0, 32'hFFFF_FF80);

    // R8: idle cycle holds the result and drops the strobe
    drive(1'b0, 32'h1111_1111, 32'h2222_2222, 32'h0, 3'd0, 3'd0, 3'd0, 2'd1, 1'b0, 1'b0);
    check("R8", {31'd0, out_valid}, 32'd0);
    check("R8", dst_out, 32'hFFFF_FF80);

    // Exhaustive selector / fill / flag sweep with random operands
    for (int sa = 0; sa < 8; sa++)
      for (int sb = 0; sb < 8; sb++)
        for (int sd = 0; sd < 8; sd++)
          for (int fm = 0; fm < 4; fm++)
            for (int fl = 0; fl < 4; fl++) begin
              a = $urandom(); b = $urandom(); o = $urandom();
              exp = ref_merge(ref_ext(a, 3'(sa), fl[0]) + ref_ext(b, 3'(sb), fl[1]),
                              o, 3'(sd), 2'(fm));
              tag = (fm == 1) ? "R6" : (fm == 2) ? "R7" : "R5";
              run(tag, a, b, o, 3'(sa), 3'(sb), 3'(sd), 2'(fm), fl[0], fl[1], exp);
            end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule